// File: doc/BRIEF.md
# Power Rail Sequencer with Hibernate

This controller drives the enables of four regulator rails and an active-low system reset from two host-side levels: a power-hold request and a low-power-mode flag. When power-hold rises, the rails come up in up to four ordered slots. Each rail waits its own programmed delay from the start of its slot. A slot ends once every rail in it reports that it is established. After the last slot, a separate delay runs before the reset is released. When power-hold falls, the reset is asserted first and the rails are dropped one cycle later. If low-power-mode is high at that moment, the block parks in a hibernate state and keeps the rails marked for hibernate.

From hibernate, the host has two ways out. It can clear low-power-mode, which shuts everything off. It can instead raise power-hold again, which starts a fresh start-up sequence. A rail survives that restart only if it is both marked for hibernate and marked as sequence-enabled. Such a rail stays on and is skipped by the sequence. A hibernate rail without the sequence-enable mark is switched off at the restart and sequenced again like any other rail.

All timing is counted in ticks of 0.5 ms. The `TICK_DIV` parameter sets how many clock cycles make one tick. Configuration arrives on static ports.

Top module: `rail_sequencer`

## Requirements
- R1: While the synchronous reset is high, and afterwards until power-hold rises, every rail enable is 0 and `rst_n` is 0.
- R2: During start-up, slots run in ascending order of their 2-bit code (rail i uses `slot_cfg[2i+1:2i]`). No rail of a later slot is enabled before every sequenced rail of the current slot is enabled and reports established. An empty slot lasts one cycle.
- R3: A rail's delay code c (rail i uses `dly_cfg[3i+2:3i]`) stands for T = 0 ticks when c = 0 and 2^(c-1) ticks otherwise, so code 1 is 0.5 ms and code 4 is 4 ms. The rail is enabled T×TICK_DIV+1 cycles after the first cycle of its slot.
- R4: After the last slot completes, `rst_n` rises 4×T(`rst_dly`)×TICK_DIV+1 cycles later, so code 4 gives 16 ms.
- R5: If power-hold is low with low-power-mode low during start-up or normal operation, `rst_n` falls on the next edge, all rails go off one edge later, and the block is off.
- R6: If low-power-mode is high on the edge where power-hold is seen low, then after the same two edges only the enabled rails with `hib_on` set remain on.
- R7: In hibernate, with power-hold low, low-power-mode going low turns every rail off on the next edge.
- R8: In hibernate, power-hold high starts a new start-up on the next edge, even if low-power-mode falls on that same edge. On that edge, the rails that are on with both `hib_on` and `seq_en` set stay on and are skipped by the sequence. Every other rail goes off.
- R9: Power-hold falling in the middle of start-up aborts the sequence. The block then takes the R5 or R6 path according to low-power-mode.
- R10: `rst_n` is high only in normal operation, and it is always low during the cycle before any rail enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_hold | input | 1 | Host power-hold request |
| lp_mode | input | 1 | Host low-power-mode flag |
| rail_good | input | NR | Per-rail "established" indication |
| slot_cfg | input | 2*NR | Per-rail sequence slot code |
| dly_cfg | input | 3*NR | Per-rail delay code |
| hib_on | input | NR | Rail stays on in hibernate |
| seq_en | input | NR | Hibernate rail survives a restart |
| rst_dly | input | 3 | Reset-release delay code |
| rail_en | output | NR | Registered rail enables |
| rst_n | output | 1 | Registered active-low system reset |

## Verification
The bench goes after four corner cases. The first is power-hold and low-power-mode changing on the same edge, both when entering hibernate and when leaving it. A design that sampled the two at different edges would fall to off instead of hibernate, or would kill the rails it should keep. The second is the restart from hibernate with the sequence-enable mark set and with it clear. Getting this wrong either glitches a rail that should stay on or leaves up a rail that should be resequenced. The third is an abort in the middle of start-up: a faulty design could finish the sequence or release reset. The fourth is the order of reset and rail shutdown, checked on every cycle, because dropping a rail while reset is still high is the fault that is most costly to miss.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int TICK_DIV = 25000,
  parameter int NR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_hold,
  input  logic            lp_mode,
  input  logic [NR-1:0]   rail_good,
  input  logic [2*NR-1:0] slot_cfg,
  input  logic [3*NR-1:0] dly_cfg,
  input  logic [NR-1:0]   hib_on,
  input  logic [NR-1:0]   seq_en,
  input  logic [2:0]      rst_dly,
  output logic [NR-1:0]   rail_en,
  output logic            rst_n
);
  localparam int SW = 2;
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int TW = 10;

  typedef enum logic [2:0] {S_OFF, S_SEQ, S_RWAIT, S_ACT, S_DOWN, S_HIB} st_t;

  st_t           st;
  logic [SW-1:0] slot;
  logic [NR-1:0] kept, in_slot, due, later;
  logic [PW-1:0] pre;
  logic [TW-1:0] tk;
  logic          hib;

  function automatic logic [TW-1:0] ticks(input logic [2:0] c);
    return (c == 3'd0) ? '0 : TW'(1) << (c - 3'd1);
  endfunction

  for (genvar i = 0; i < NR; i++) begin : g_rail
    assign in_slot[i] = (slot_cfg[SW*i +: SW] == slot) && !kept[i];
    assign due[i]     = tk >= ticks(dly_cfg[3*i +: 3]);
    assign later[i]   = slot_cfg[SW*i +: SW] > slot;
  end

  wire step_done = &(~in_slot | (rail_en & rail_good));
  wire rst_due   = tk >= (ticks(rst_dly) << 2);
  wire tick      = pre == PW'(TICK_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OFF; rail_en <= '0; rst_n <= 1'b0; kept <= '0;
      slot <= '0; pre <= '0; tk <= '0; hib <= 1'b0;
    end else begin
      if (tick) begin
        pre <= '0;
        if (tk != '1) tk <= tk + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      case (st)
        S_OFF: if (pwr_hold) begin
          st <= S_SEQ; slot <= '0; kept <= '0; pre <= '0; tk <= '0;
        end
        S_SEQ: begin
          if (!pwr_hold) begin
            st <= S_DOWN; rst_n <= 1'b0; hib <= lp_mode;
          end else if (step_done) begin
            pre <= '0; tk <= '0;
            if (slot == '1) st <= S_RWAIT;
            else slot <= slot + 1'b1;
          end else begin
            rail_en <= rail_en | (in_slot & due);
          end
        end
        S_RWAIT: begin
          if (!pwr_hold) begin
            st <= S_DOWN; rst_n <= 1'b0; hib <= lp_mode;
          end else if (rst_due) begin
            st <= S_ACT; rst_n <= 1'b1;
          end
        end
        S_ACT: if (!pwr_hold) begin
          st <= S_DOWN; rst_n <= 1'b0; hib <= lp_mode;
        end
        S_DOWN: begin
          rail_en <= hib ? (rail_en & hib_on) : '0;
          st <= hib ? S_HIB : S_OFF;
        end
        S_HIB: begin
          if (pwr_hold) begin
            kept <= rail_en & hib_on & seq_en;
            rail_en <= rail_en & hib_on & seq_en;
            st <= S_SEQ; slot <= '0; pre <= '0; tk <= '0;
          end else if (!lp_mode) begin
            rail_en <= '0; st <= S_OFF;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_SEQ) |-> ((rail_en & later & ~kept) == '0));

  p_hib_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_HIB) |-> ((rail_en & ~hib_on) == '0));

  p_off_dark_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_OFF) |-> (rail_en == '0 && !rst_n));

  p_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_SEQ && $past(st) == S_HIB) |->
      (rail_en == ($past(rail_en) & $past(hib_on) & $past(seq_en))));

  p_rst_first_r10: assert property (@(posedge clk) disable iff (rst)
    (|($past(rail_en) & ~rail_en)) |-> !$past(rst_n));
endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
  localparam int DIV = 4;
  localparam int M_OFF = 0, M_SEQ = 1, M_RW = 2, M_ACT = 3, M_DOWN = 4, M_HIB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, ph = 1'b0, lp = 1'b0;
  logic [3:0] good = '0, hibm, seqm;
  logic [7:0] slots;
  logic [11:0] dlys;
  logic [2:0] rdly;
  logic [3:0] en;
  logic rstn;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m = M_OFF, s = 0, el = 0;
  logic [3:0] e_en = '0, kept = '0;
  logic e_rstn = 1'b0, lat = 1'b0;
  logic [3:0] prev_en = '0;
  logic prev_rstn = 1'b0;
  int lagc [4];
  int lag [4] = '{3, 2, 5, 1};

  always #10 clk = ~clk;

  rail_sequencer #(.TICK_DIV(DIV), .NR(4)) u_rail_sequencer (
    .clk(clk), .rst(rst), .pwr_hold(ph), .lp_mode(lp), .rail_good(good),
    .slot_cfg(slots), .dly_cfg(dlys), .hib_on(hibm), .seq_en(seqm),
    .rst_dly(rdly), .rail_en(en), .rst_n(rstn));

  function automatic int tk(input int c);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // reference model
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m = M_OFF; e_en = '0; e_rstn = 1'b0; kept = '0; s = 0; el = 0;
    end else begin
      case (m)
        M_OFF: if (ph) begin m = M_SEQ; s = 0; el = 0; kept = '0; end
        M_SEQ: begin
          if (!ph) begin m = M_DOWN; e_rstn = 1'b0; lat = lp; end
          else begin
            bit done;
            done = 1'b1;
            for (int r = 0; r < 4; r++)
              if (int'(slots[2*r +: 2]) == s && !kept[r] && !(e_en[r] && good[r])) done = 1'b0;
            if (done) begin
              el = 0;
              if (s == 3) m = M_RW; else s++;
            end else begin
              for (int r = 0; r < 4; r++)
                if (int'(slots[2*r +: 2]) == s && !kept[r] && el >= tk(int'(dlys[3*r +: 3])) * DIV)
                  e_en[r] = 1'b1;
              el++;
            end
          end
        end
        M_RW: begin
          if (!ph) begin m = M_DOWN; e_rstn = 1'b0; lat = lp; end
          else if (el >= 4 * tk(int'(rdly)) * DIV) begin m = M_ACT; e_rstn = 1'b1; end
          else el++;
        end
        M_ACT: if (!ph) begin m = M_DOWN; e_rstn = 1'b0; lat = lp; end
        M_DOWN: begin
          e_en = lat ? (e_en & hibm) : '0;
          m = lat ? M_HIB : M_OFF;
        end
        M_HIB: begin
          if (ph) begin
            kept = e_en & hibm & seqm; e_en = kept; m = M_SEQ; s = 0; el = 0;
          end else if (!lp) begin
            e_en = '0; m = M_OFF;
          end
        end
        default: m = M_OFF;
      endcase
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // rail establishment and per-cycle comparison
  always @(negedge clk) begin
    string tag;
    case (m)
      M_OFF: tag = "R1";
      M_SEQ: tag = "R2/R3";
      M_RW, M_ACT: tag = "R4";
      M_DOWN: tag = "R5";
      default: tag = "R6";
    endcase
    chk(en == e_en, tag, int'(en), int'(e_en));
    chk(rstn == e_rstn, tag, int'(rstn), int'(e_rstn));
    if (!rst) chk(!((|(prev_en & ~en)) && prev_rstn), "R10", int'(prev_rstn), 0);
    prev_en = en; prev_rstn = rstn;
    for (int i = 0; i < 4; i++) begin
      if (!en[i]) begin lagc[i] = 0; good[i] = 1'b0; end
      else begin lagc[i]++; good[i] = (lagc[i] >= lag[i]); end
    end
  end

  task automatic drv(input logic p, input logic l);
    @(posedge clk); #2; ph = p; lp = l;
  endtask

  task automatic smp();
    @(posedge clk); #8;
  endtask

  task automatic wait_mode(input int t, input string tag);
    int i;
    for (i = 0; i < 5000; i++) begin
      @(posedge clk); #1;
      if (m == t) break;
    end
    #7;
    chk(m == t, tag, m, t);
  endtask

  initial begin
    slots = {2'd2, 2'd2, 2'd1, 2'd0};
    dlys  = {3'd4, 3'd4, 3'd2, 3'd1};
    hibm = 4'b0010; seqm = 4'b1111; rdly = 3'd4;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    smp();
    chk(en == 4'b0 && !rstn, "R1", int'({rstn, en}), 0);

    // normal start-up then full power-down
    drv(1, 0);
    wait_mode(M_ACT, "R4");
    chk(en == 4'b1111 && rstn, "R4", int'({rstn, en}), 5'h1f);
    drv(0, 0);
    smp();
    chk(!rstn && en == 4'b1111, "R10", int'({rstn, en}), 4'hf);
    smp();
    chk(en == 4'b0, "R5", int'(en), 0);

    // start-up, hibernate with simultaneous edge, restart with simultaneous edge
    drv(1, 0);
    wait_mode(M_ACT, "R4");
    drv(0, 1);
    smp(); smp();
    chk(en == 4'b0010 && m == M_HIB, "R6", int'(en), 2);
    drv(1, 0);
    smp();
    chk(en == 4'b0010, "R8", int'(en), 2);
    wait_mode(M_ACT, "R8");
    chk(en == 4'b1111, "R8", int'(en), 15);

    // hibernate rail without sequence-enable is dropped at restart
    drv(0, 1);
    smp(); smp();
    chk(en == 4'b0010, "R6", int'(en), 2);
    seqm = 4'b1101;
    drv(1, 1);
    smp();
    chk(en == 4'b0000, "R8", int'(en), 0);
    drv(1, 0);
    wait_mode(M_ACT, "R8");

    // hibernate then leave through low-power-mode low
    drv(0, 1);
    smp(); smp();
    drv(0, 0);
    smp();
    chk(en == 4'b0 && m == M_OFF, "R7", int'(en), 0);

    // abort during start-up into hibernate
    drv(1, 1);
    for (int i = 0; i < 200 && !en[0]; i++) smp();
    drv(0, 1);
    smp();
    chk(!rstn, "R9", int'(rstn), 0);
    smp();
    chk(en == 4'b0 && m == M_HIB, "R9", int'(en), 0);
    drv(0, 0);
    smp();
    chk(m == M_OFF, "R7", m, M_OFF);

    // all rails in one slot with zero delays
    slots = 8'h00; dlys = 12'h000; rdly = 3'd0; seqm = 4'b1111;
    drv(1, 0);
    wait_mode(M_ACT, "R3");
    chk(en == 4'b1111, "R2", int'(en), 15);
    drv(0, 0);
    smp(); smp();
    chk(en == 4'b0, "R5", int'(en), 0);
    repeat (4) smp();
    finish_run();
  end
endmodule